// File: doc/BRIEF.md
# Network Controller Serial EEPROM Control Registers

This block holds the serial-EEPROM control register and four configuration bytes of an NE2000-class network controller. The top two bits of the control register pick one of four modes:

- **Normal:** the EEPROM pins stay idle.
- **Program:** host software drives chip select, serial clock and data-in one register write at a time. It reads the EEPROM data-out line back through bit 0 of the same register.
- **Auto-load:** the block runs a 93C46-style serial read of its own. It fetches the first two 16-bit words and copies them into the four configuration bytes.
- **Config-write:** the configuration bytes become writable from the host.

Register writes arrive on a valid/ready channel. Reads are a plain combinational mux selected by `rd_sel`.

Write channel rules:
- A write takes effect on a rising clock edge where both `wr_valid` and `wr_ready` are high.
- The sender must hold `wr_sel` and `wr_data` steady while `wr_valid` is high and not yet accepted.
- `wr_ready` is low for the whole of an auto-load. A write offered during a load is therefore stalled, not dropped, and lands on the first edge after the load ends.

At the end of an auto-load the block pulses `main_cmd_load` for one cycle, with `main_cmd_value` = 0x21. The neighbouring main command register uses this pulse to reload itself.

Top module: `nic_eectl`

## Requirements
- R1: After reset:
  - the configuration bytes read 0x00, 0x00, 0x40, 0x40 (index 0 to 3);
  - the control register reads 0x00 with bit 0 equal to `ee_do`;
  - `load_busy` is low, `wr_ready` is high, and `ee_cs`, `ee_sk`, `ee_di` are low.
- R2: `rd_sel` codes:
  - 000 returns the stored control bits 7:1, with bit 0 replaced by the live `ee_do` pin;
  - 1xx returns configuration byte xx;
  - 001 to 011 read as zero.
- R3: Pin driving depends on the mode bits 7:6 of the control register:
  - mode 10 (program), outside a load: `ee_cs` = bit 3, `ee_sk` = bit 2, `ee_di` = bit 1;
  - modes 00 and 11: all three pins are held low.
- R4: A write with `wr_sel` = 1xx stores `wr_data` in configuration byte xx only while the mode bits are 11. In any other mode it leaves all four bytes unchanged.
- R5: Writing control mode 01 starts an auto-load, and `load_busy` is high from the next cycle.
  - Each word is fetched with CS high. The fetch is a start bit 1, opcode 10, a 6-bit word address MSB first, then 16 data bits MSB first.
  - DI changes while SK is low. Data-out is sampled at the end of each SK-high phase.
  - SK low and high phases each last `SK_HALF_CYCLES` clocks.
  - CS rises one phase before the first SK pulse and falls for one phase after the last.
  - `load_busy` therefore lasts 2 × (2 + 2 × 25) × `SK_HALF_CYCLES` cycles (208 at defaults).
- R6: Byte mapping on load completion:
  - configuration byte 0 = word 0 bits 7:0, byte 1 = word 0 bits 15:8;
  - byte 2 = word 1 bits 7:0, byte 3 = word 1 bits 15:8.
  - All four change together in the cycle after the last load cycle. Until then they read their old values.
- R7: `wr_ready` is low for every cycle in which `load_busy` is high. A write held valid through a load is accepted on the first edge after the load ends.
- R8: When a load ends:
  - `main_cmd_load` is high for exactly one cycle, the first cycle with `load_busy` low, with `main_cmd_value` = 0x21;
  - the control register mode bits return to 00 and bits 5:1 keep the value written.
- R9: In program mode, a host-driven read sequence (the same framing as R5) returns through control bit 0 the 16-bit content of any of the 64 EEPROM words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Register write offered |
| wr_ready | output | 1 | Write can be accepted (low during auto-load) |
| wr_sel | input | 3 | Write target: 000 control, 1xx configuration byte xx |
| wr_data | input | 8 | Write data |
| rd_sel | input | 3 | Read selector, same coding as `wr_sel` |
| rd_data | output | 8 | Read data |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_di | output | 1 | EEPROM serial data in |
| ee_do | input | 1 | EEPROM serial data out |
| load_busy | output | 1 | Auto-load in progress |
| main_cmd_load | output | 1 | One-cycle request to load the main command register |
| main_cmd_value | output | 8 | Value for the main command register (0x21) |

## Verification
The assertions assume that a sender keeps `wr_valid` and its payload steady until it is accepted. They also assume the EEPROM changes `ee_do` only in response to a rising `ee_sk` while `ee_cs` is high. The bench drives every write from one task that changes inputs only on falling edges and holds them until `wr_ready` is seen. Its EEPROM model updates data-out only on serial-clock edges, so both assumptions hold throughout the stimulus. In program mode the bench always raises chip select in a write of its own, before the first clock pulse, so the model's command framing starts cleanly.

// File: rtl/nic_eectl_pkg.sv
package nic_eectl_pkg;
  localparam int CFG_REGS   = 4;
  localparam int EE_WORD_W  = 16;
  localparam int LOAD_WORDS = CFG_REGS * 8 / EE_WORD_W;

  typedef enum logic [1:0] {
    MODE_NORMAL   = 2'b00,
    MODE_AUTOLOAD = 2'b01,
    MODE_PROGRAM  = 2'b10,
    MODE_CFGWR    = 2'b11
  } ee_mode_e;

  typedef enum logic [2:0] {
    LD_IDLE,
    LD_SETUP,
    LD_LOW,
    LD_HIGH,
    LD_GAP
  } ld_state_e;

  localparam logic [2:0] SEL_CMD = 3'b000;

  function automatic logic [7:0] cfg_reset_val(input int idx);
    return (idx >= 2) ? 8'h40 : 8'h00;
  endfunction
endpackage

// File: rtl/nic_eectl_loader.sv
module nic_eectl_loader
  import nic_eectl_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int HALF_CYCLES = 2,
  parameter int WORD_W      = 16,
  parameter int N_WORDS     = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic                      ee_do,
  output logic                      busy,
  output logic                      done,
  output logic                      eng_cs,
  output logic                      eng_sk,
  output logic                      eng_di,
  output logic [N_WORDS*WORD_W-1:0] words
);
  localparam int CMD_BITS = 3 + ADDR_W;
  localparam int SLOTS    = CMD_BITS + WORD_W;
  localparam int DIV_W    = (HALF_CYCLES > 1) ? $clog2(HALF_CYCLES) : 1;
  localparam int SLOT_W   = $clog2(SLOTS + 1);
  localparam int WIDX_W   = (N_WORDS > 1) ? $clog2(N_WORDS) : 1;
  localparam logic [DIV_W-1:0]  DIV_LAST   = DIV_W'(HALF_CYCLES - 1);
  localparam logic [SLOT_W-1:0] SLOT_LAST  = SLOT_W'(SLOTS - 1);
  localparam logic [SLOT_W-1:0] SLOT_DATA0 = SLOT_W'(CMD_BITS);
  localparam logic [WIDX_W-1:0] WIDX_LAST  = WIDX_W'(N_WORDS - 1);

  ld_state_e           state_q;
  logic [DIV_W-1:0]    div_q;
  logic [SLOT_W-1:0]   slot_q;
  logic [WIDX_W-1:0]   widx_q;
  logic [WORD_W-1:0]   shift_q;
  logic [CMD_BITS-1:0] cmd_sh_q;
  logic [WORD_W-1:0]   word_q [N_WORDS];
  logic                phase_end;
  logic                last_bit;
  logic [WORD_W-1:0]   shift_nx;

  // Start bit, READ opcode, then the word address MSB first.
  function automatic logic [CMD_BITS-1:0] read_cmd(input logic [WIDX_W-1:0] w);
    return {3'b110, ADDR_W'(w)};
  endfunction

  assign phase_end = (div_q == DIV_LAST);
  assign shift_nx  = {shift_q[WORD_W-2:0], ee_do};
  assign last_bit  = (state_q == LD_HIGH) && phase_end && (slot_q == SLOT_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= LD_IDLE;
      div_q    <= '0;
      slot_q   <= '0;
      widx_q   <= '0;
      shift_q  <= '0;
      cmd_sh_q <= '0;
    end else begin
      div_q <= (state_q == LD_IDLE || phase_end) ? '0 : div_q + 1'b1;
      case (state_q)
        LD_IDLE: begin
          if (start) begin
            state_q  <= LD_SETUP;
            widx_q   <= '0;
            slot_q   <= '0;
            cmd_sh_q <= read_cmd('0);
          end
        end
        LD_SETUP: if (phase_end) state_q <= LD_LOW;
        LD_LOW:   if (phase_end) state_q <= LD_HIGH;
        LD_HIGH: begin
          if (phase_end) begin
            cmd_sh_q <= cmd_sh_q << 1;
            if (slot_q >= SLOT_DATA0) shift_q <= shift_nx;
            if (slot_q == SLOT_LAST) begin
              state_q <= LD_GAP;
            end else begin
              slot_q  <= slot_q + 1'b1;
              state_q <= LD_LOW;
            end
          end
        end
        LD_GAP: begin
          if (phase_end) begin
            slot_q <= '0;
            if (widx_q == WIDX_LAST) begin
              state_q <= LD_IDLE;
            end else begin
              widx_q   <= widx_q + 1'b1;
              cmd_sh_q <= read_cmd(WIDX_W'(widx_q + 1'b1));
              state_q  <= LD_SETUP;
            end
          end
        end
        default: state_q <= LD_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N_WORDS; i++) word_q[i] <= '0;
    end else if (last_bit) begin
      word_q[widx_q] <= shift_nx;
    end
  end

  for (genvar g = 0; g < N_WORDS; g++) begin : g_words
    assign words[g*WORD_W +: WORD_W] = word_q[g];
  end

  assign busy   = (state_q != LD_IDLE);
  assign done   = (state_q == LD_GAP) && phase_end && (widx_q == WIDX_LAST);
  assign eng_cs = (state_q == LD_SETUP) || (state_q == LD_LOW) || (state_q == LD_HIGH);
  assign eng_sk = (state_q == LD_HIGH);
  assign eng_di = ((state_q == LD_LOW) || (state_q == LD_HIGH)) && cmd_sh_q[CMD_BITS-1];

  // R5: the serial clock only pulses with the device selected
  a_r5_sk_inside_cs: assert property (@(posedge clk) disable iff (!rst_n)
    eng_sk |-> eng_cs);
  // R5: an accepted start makes the engine busy on the next cycle
  a_r5_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  // R5: the final cycle of a load is followed by idle
  a_r5_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
endmodule

// File: rtl/nic_eectl_regs.sv
module nic_eectl_regs
  import nic_eectl_pkg::*;
#(
  parameter int WORD_W  = 16,
  parameter int N_WORDS = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_fire,
  input  logic [2:0]                   wr_sel,
  input  logic [7:0]                   wr_data,
  input  logic                         ld_done,
  input  logic                         ld_busy,
  input  logic [N_WORDS*WORD_W-1:0]    ld_words,
  output logic [7:1]                   cmd_hi_q,
  output logic [CFG_REGS-1:0][7:0]     cfg_q,
  output logic                         start_load
);
  logic [CFG_REGS-1:0][7:0] ld_bytes;
  logic cmd_wr;
  logic cfg_wr;

  // Loaded words are little-endian: byte k sits at bit 8k of the word stream.
  for (genvar g = 0; g < CFG_REGS; g++) begin : g_bytes
    assign ld_bytes[g] = ld_words[g*8 +: 8];
  end

  assign cmd_wr     = wr_fire && (wr_sel == SEL_CMD);
  assign cfg_wr     = wr_fire && wr_sel[2] && (cmd_hi_q[7:6] == MODE_CFGWR);
  assign start_load = cmd_wr && (wr_data[7:6] == MODE_AUTOLOAD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_hi_q <= '0;
    end else if (cmd_wr) begin
      cmd_hi_q <= wr_data[7:1];
    end else if (ld_done) begin
      cmd_hi_q[7:6] <= MODE_NORMAL;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < CFG_REGS; i++) cfg_q[i] <= cfg_reset_val(i);
    end else if (ld_done) begin
      cfg_q <= ld_bytes;
    end else if (cfg_wr) begin
      cfg_q[wr_sel[1:0]] <= wr_data;
    end
  end

  // R6: configuration bytes are frozen while a load is still running
  a_r6_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_busy && !ld_done) |=> $stable(cfg_q));
  // R4: a configuration change always traces back to a load end or an unlocked write
  a_r4_cfg_cause: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_q) |-> ($past(ld_done) || $past(cfg_wr)));
endmodule

// File: rtl/nic_eectl_pinmux.sv
module nic_eectl_pinmux
  import nic_eectl_pkg::*;
(
  input  logic       ld_busy,
  input  logic       eng_cs,
  input  logic       eng_sk,
  input  logic       eng_di,
  input  logic [1:0] mode,
  input  logic [2:0] bang,
  output logic       ee_cs,
  output logic       ee_sk,
  output logic       ee_di
);
  always_comb begin
    if (ld_busy) begin
      {ee_cs, ee_sk, ee_di} = {eng_cs, eng_sk, eng_di};
    end else if (mode == MODE_PROGRAM) begin
      {ee_cs, ee_sk, ee_di} = bang;
    end else begin
      {ee_cs, ee_sk, ee_di} = 3'b000;
    end
  end
endmodule

// File: rtl/nic_eectl.sv
module nic_eectl
  import nic_eectl_pkg::*;
#(
  parameter int         EE_ADDR_W      = 6,
  parameter int         SK_HALF_CYCLES = 2,
  parameter logic [7:0] MAIN_CMD_VAL   = 8'h21
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_valid,
  output logic       wr_ready,
  input  logic [2:0] wr_sel,
  input  logic [7:0] wr_data,
  input  logic [2:0] rd_sel,
  output logic [7:0] rd_data,
  output logic       ee_cs,
  output logic       ee_sk,
  output logic       ee_di,
  input  logic       ee_do,
  output logic       load_busy,
  output logic       main_cmd_load,
  output logic [7:0] main_cmd_value
);
  logic                             wr_fire;
  logic                             start_load;
  logic                             ld_done;
  logic                             eng_cs, eng_sk, eng_di;
  logic [LOAD_WORDS*EE_WORD_W-1:0]  ld_words;
  logic [7:1]                       cmd_hi_q;
  logic [CFG_REGS-1:0][7:0]         cfg_q;
  logic                             main_load_q;

  assign wr_ready = !load_busy;
  assign wr_fire  = wr_valid && wr_ready;

  nic_eectl_loader #(
    .ADDR_W     (EE_ADDR_W),
    .HALF_CYCLES(SK_HALF_CYCLES),
    .WORD_W     (EE_WORD_W),
    .N_WORDS    (LOAD_WORDS)
  ) loader_i (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start_load),
    .ee_do (ee_do),
    .busy  (load_busy),
    .done  (ld_done),
    .eng_cs(eng_cs),
    .eng_sk(eng_sk),
    .eng_di(eng_di),
    .words (ld_words)
  );

  nic_eectl_regs #(
    .WORD_W (EE_WORD_W),
    .N_WORDS(LOAD_WORDS)
  ) regs_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_fire   (wr_fire),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .ld_done   (ld_done),
    .ld_busy   (load_busy),
    .ld_words  (ld_words),
    .cmd_hi_q  (cmd_hi_q),
    .cfg_q     (cfg_q),
    .start_load(start_load)
  );

  nic_eectl_pinmux pinmux_i (
    .ld_busy(load_busy),
    .eng_cs (eng_cs),
    .eng_sk (eng_sk),
    .eng_di (eng_di),
    .mode   (cmd_hi_q[7:6]),
    .bang   (cmd_hi_q[3:1]),
    .ee_cs  (ee_cs),
    .ee_sk  (ee_sk),
    .ee_di  (ee_di)
  );

  always_comb begin
    if (rd_sel == SEL_CMD)  rd_data = {cmd_hi_q, ee_do};
    else if (rd_sel[2])     rd_data = cfg_q[rd_sel[1:0]];
    else                    rd_data = 8'h00;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) main_load_q <= 1'b0;
    else        main_load_q <= ld_done;
  end

  assign main_cmd_load  = main_load_q;
  assign main_cmd_value = MAIN_CMD_VAL;

  // R8: the reload request appears in the first idle cycle after a load
  a_r8_pulse_after_load: assert property (@(posedge clk) disable iff (!rst_n)
    main_cmd_load |-> (!load_busy && $past(load_busy)));
  // R3: outside program mode and loads the EEPROM pins rest low
  a_r3_pins_rest: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_busy && (cmd_hi_q[7:6] != MODE_PROGRAM)) |-> (!ee_cs && !ee_sk && !ee_di));
  // R7: no write is accepted while loading
  a_r7_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
    (load_busy && wr_valid && wr_sel == SEL_CMD) |=> $stable(cmd_hi_q[5:1]));
endmodule

// File: tb/nic_eectl_tb.sv
`timescale 1ns/100ps
module nic_eectl_tb_top;
  localparam int ADDR_W   = 6;
  localparam int HALF     = 2;
  localparam int EXP_BUSY = 2 * (2 + 2 * (3 + ADDR_W + 16)) * HALF;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_valid = 1'b0;
  logic       wr_ready;
  logic [2:0] wr_sel = 3'b000;
  logic [7:0] wr_data = 8'h00;
  logic [2:0] rd_sel = 3'b000;
  logic [7:0] rd_data;
  logic       ee_cs, ee_sk, ee_di, ee_do;
  logic       load_busy, main_cmd_load;
  logic [7:0] main_cmd_value;
  logic       do_force = 1'b0;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  nic_eectl #(.EE_ADDR_W(ADDR_W), .SK_HALF_CYCLES(HALF), .MAIN_CMD_VAL(8'h21)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
    .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do),
    .load_busy(load_busy), .main_cmd_load(main_cmd_load), .main_cmd_value(main_cmd_value)
  );

  // Behavioural 64 x 16 serial EEPROM
  logic [15:0] ee_mem [64];
  int unsigned m_cnt = 0;
  logic [7:0]  m_hist = 8'h00;
  logic [15:0] m_data = 16'h0000;
  logic        m_do = 1'b0;
  int          bad_cmd = 0;

  assign ee_do = m_do ^ do_force;

  always @(posedge ee_sk or negedge ee_cs) begin
    if (!ee_cs) begin
      m_cnt <= 0;
      m_do  <= 1'b0;
    end else begin
      if (m_cnt < 8) begin
        m_hist <= {m_hist[6:0], ee_di};
      end else if (m_cnt == 8) begin
        if (m_hist[7:5] != 3'b110) bad_cmd <= bad_cmd + 1;
        m_data <= ee_mem[{m_hist[4:0], ee_di}];
        m_do   <= 1'b0;
      end else if (m_cnt < 25) begin
        m_do   <= m_data[15];
        m_data <= {m_data[14:0], 1'b0};
      end
      if (m_cnt < 31) m_cnt <= m_cnt + 1;
    end
  end

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [7:0] d);
    @(negedge clk);
    wr_sel = s; wr_data = d; wr_valid = 1'b1;
    while (!wr_ready) @(negedge clk);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic rd(input logic [2:0] s, output logic [7:0] v);
    rd_sel = s;
    #0.5;
    v = rd_data;
  endtask

  function automatic logic [7:0] bang_val(input logic cs, input logic sk, input logic di);
    return {4'b1000, cs, sk, di, 1'b0};
  endfunction

  task automatic bang_read(input logic [5:0] a, output logic [15:0] w);
    logic [8:0] c;
    logic [7:0] v;
    c = {3'b110, a};
    wr(3'b000, bang_val(1'b1, 1'b0, 1'b0));
    for (int b = 8; b >= 0; b--) begin
      wr(3'b000, bang_val(1'b1, 1'b0, c[b]));
      wr(3'b000, bang_val(1'b1, 1'b1, c[b]));
    end
    w = '0;
    for (int b = 0; b < 16; b++) begin
      wr(3'b000, bang_val(1'b1, 1'b0, 1'b0));
      wr(3'b000, bang_val(1'b1, 1'b1, 1'b0));
      rd(3'b000, v);
      w = {w[14:0], v[0]};
    end
    wr(3'b000, bang_val(1'b0, 1'b0, 1'b0));
  endtask

  task automatic run_load(input logic [7:0] cmdv, input logic hold, input logic [7:0] held);
    logic [7:0] old [4];
    logic [7:0] v;
    logic [7:0] exp_b [4];
    int busy_cyc;
    int frozen_bad;
    int bad_base;
    for (int i = 0; i < 4; i++) rd(3'(4 + i), old[i]);
    bad_base = bad_cmd;
    wr(3'b000, cmdv);
    chk("R5", "busy after start", load_busy, 1);
    chk("R7", "ready during load", wr_ready, 0);
    if (hold) begin
      wr_sel = 3'b000; wr_data = held; wr_valid = 1'b1;
    end
    busy_cyc = 0;
    frozen_bad = 0;
    while (load_busy) begin
      busy_cyc++;
      for (int i = 0; i < 4; i++) begin
        rd(3'(4 + i), v);
        if (v !== old[i]) frozen_bad++;
      end
      if (wr_ready) frozen_bad++;
      @(negedge clk);
    end
    chk("R5", "busy length", busy_cyc, EXP_BUSY);
    chk("R6", "cfg frozen and ready low during load", frozen_bad, 0);
    chk("R5", "serial command framing", bad_cmd - bad_base, 0);
    chk("R8", "reload pulse", main_cmd_load, 1);
    chk("R8", "reload value", main_cmd_value, 8'h21);
    exp_b[0] = ee_mem[0][7:0];
    exp_b[1] = ee_mem[0][15:8];
    exp_b[2] = ee_mem[1][7:0];
    exp_b[3] = ee_mem[1][15:8];
    for (int i = 0; i < 4; i++) begin
      rd(3'(4 + i), v);
      chk("R6", "loaded byte", v, exp_b[i]);
    end
    rd(3'b000, v);
    chk("R8", "mode cleared after load", v, {2'b00, cmdv[5:1], ee_do});
    @(negedge clk);
    chk("R8", "pulse lasts one cycle", main_cmd_load, 0);
    if (hold) begin
      wr_valid = 1'b0;
      rd(3'b000, v);
      chk("R7", "held write lands after load", v, {held[7:1], ee_do});
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    logic [7:0]  v;
    logic [15:0] w;
    int          mism;
    ee_mem[0] = 16'h0080;
    ee_mem[1] = 16'h0010;
    ee_mem[2] = 16'h4E02;
    ee_mem[3] = 16'h7C1A;
    ee_mem[4] = 16'hE593;
    for (int i = 5; i < 64; i++) ee_mem[i] = 16'(i * 16'h1D37) ^ 16'hB4C1;

    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(3'b000, v); chk("R1", "control reset", v, 8'h00);
    rd(3'b100, v); chk("R1", "cfg0 reset", v, 8'h00);
    rd(3'b101, v); chk("R1", "cfg1 reset", v, 8'h00);
    rd(3'b110, v); chk("R1", "cfg2 reset", v, 8'h40);
    rd(3'b111, v); chk("R1", "cfg3 reset", v, 8'h40);
    chk("R1", "busy/ready/pins", {load_busy, wr_ready, ee_cs, ee_sk, ee_di}, 5'b01000);

    // R2 live data-out in bit 0, unused selectors
    wr(3'b000, 8'h3E);
    do_force = 1'b1; rd(3'b000, v); chk("R2", "bit0 follows do high", v, 8'h3F);
    do_force = 1'b0; rd(3'b000, v); chk("R2", "bit0 follows do low", v, 8'h3E);
    wr(3'b000, 8'h3F);
    rd(3'b000, v); chk("R2", "stored bit0 not returned", v, 8'h3E);
    for (int s = 1; s < 4; s++) begin
      wr(3'(s), 8'hFF);
      rd(3'(s), v); chk("R2", "unused selector reads zero", v, 8'h00);
    end

    // R3 pin sweep over modes 00, 10, 11
    for (int m = 0; m < 4; m++) begin
      if (m == 1) continue;
      for (int b = 0; b < 16; b++) begin
        wr(3'b000, {2'(m), 2'b00, 4'(b)});
        chk("R3", "pin drive", {ee_cs, ee_sk, ee_di}, (m == 2) ? 3'(b >> 1) : 3'b000);
      end
    end
    wr(3'b000, 8'h00);

    // R4 config writes locked outside mode 11
    for (int m = 0; m < 3; m += 2) begin
      wr(3'b000, {2'(m), 6'b0});
      mism = 0;
      for (int i = 0; i < 4; i++) begin
        wr(3'(4 + i), 8'hA5 ^ 8'(i));
        rd(3'(4 + i), v);
        if (v !== ((i >= 2) ? 8'h40 : 8'h00)) mism++;
      end
      chk("R4", "locked config write ignored", mism, 0);
    end
    wr(3'b000, 8'hC0);
    for (int i = 0; i < 4; i++) begin
      wr(3'(4 + i), 8'h3C + 8'(i * 17));
      rd(3'(4 + i), v); chk("R4", "unlocked config write", v, 8'h3C + 8'(i * 17));
    end

    // R5..R8 auto-load with a write held through it
    run_load(8'h4E, 1'b1, 8'hC6);
    // second load with different contents
    ee_mem[0] = 16'h5AC3;
    ee_mem[1] = 16'h0F96;
    run_load(8'h40, 1'b0, 8'h00);

    // R9 bit-banged reads of every word
    for (int a = 0; a < 64; a++) begin
      bang_read(6'(a), w);
      chk("R9", "bit-bang word", w, ee_mem[a]);
    end

    summary();
    $finish;
  end
endmodule